// File: doc/BRIEF.md
# Display Mode Register Interface

This block is a small bank of 16-bit mode registers that a host programs to bring up a linear-framebuffer graphics mode. The host sees two 16-bit locations. Offset 0 is a pointer that picks a register. Offset 1 is a window onto the register that the pointer selects. Read data is combinational, so it is valid in the same cycle as the access.

The bank holds the identification value, the requested horizontal and vertical resolution, colour depth, the enable word, a bank number, the virtual canvas size and the pan offsets. It also holds a read-only memory-size word expressed in 64 KiB units. Setting bit 0 of the enable word while it is clear counts as a mode set. On a mode set the requested resolution is checked against the framebuffer capacity, and the active width, height and stride outputs are updated only when it fits. Every mode set also reseeds the virtual size from the requested resolution and zeroes the pan offsets. When bit 1 of the enable word is set, reads of the resolution and depth indices report the active geometry instead of the stored values.

Top module: `dispmode_regs`

## Requirements
- R1: A write at offset 0 loads the full 16-bit pointer, and a read at offset 0 returns it. Accesses at offset 1 act on the register the pointer selects.
- R2: After reset, index 0 (identification) reads 0xB0C5 and index 0xA (memory size) reads FB_BYTES>>16. Every other stored register reads 0. The active outputs equal INIT_WIDTH, INIT_HEIGHT and INIT_WIDTH*4.
- R3: A write to index 0 is accepted only when the value lies in 0xB0C0..0xB0C5. Any other value leaves the register unchanged.
- R4: A mode set is a write to index 4 with bit 0 set while the stored bit 0 is clear. On a mode set, if X (index 1) ≤ 4096, Y (index 2) ≤ 4096 and X*4*Y ≤ FB_BYTES, the next cycle shows active width X, active height Y and stride X*4. Otherwise the active outputs keep their values.
- R5: Every mode set loads index 6 from index 1 and index 7 from index 2, and clears indices 8 and 9, whether or not the size check passes.
- R6: The written enable value is always stored in full, including bits 5, 6 and 7. A write with bit 0 set while bit 0 is already stored set has no side effect on the active outputs or on indices 6 to 9.
- R7: While stored enable bit 1 is set, a data read of index 1 returns the active width, index 2 returns the active height and index 3 returns 32. Other indices read normally.
- R8: A data read with the pointer at 11 or above returns 0. Writes to index 0xA and to indices 11 and above change nothing.
- R9: Indices 1, 2, 3, 5, 6, 7, 8 and 9 store any 16-bit value written to them.
- R10: A resolution above 4096 in either axis fails the size check even when the product would fit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| off_i | input | 1 | 0 = pointer, 1 = data window |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the access cycle |
| act_width_o | output | 16 | Active width in pixels |
| act_height_o | output | 16 | Active height in lines |
| act_stride_o | output | 18 | Active line pitch in bytes |

## Verification
The size check is exercised with a resolution whose product lands exactly on the framebuffer size, one a single column over, a width at the 4096 limit, and a width one past it with a tiny height. Together these separate the `≤` comparison from a `<`, and the per-axis limit from the product test. Mode sets are compared with enable re-writes while bit 0 is already set, which shows whether the rising-edge detection is present. Capability reads are taken with stored resolution and depth values that differ from the active geometry, so the override cannot be confused with a normal read. The identification filter is probed at both ends of its range and one step outside each end.

// File: rtl/dispmode_pkg.sv
`timescale 1ns/1ps
package dispmode_pkg;
  localparam int DW       = 16;
  localparam int SW       = DW + 2;
  localparam int NUM_RW   = 10;
  localparam int NUM_REG  = 11;
  localparam int MAX_RES  = 4096;
  localparam int CAP_BPP  = 32;

  localparam logic [DW-1:0] IDX_ID    = 16'd0;
  localparam logic [DW-1:0] IDX_XRES  = 16'd1;
  localparam logic [DW-1:0] IDX_YRES  = 16'd2;
  localparam logic [DW-1:0] IDX_BPP   = 16'd3;
  localparam logic [DW-1:0] IDX_EN    = 16'd4;
  localparam logic [DW-1:0] IDX_BANK  = 16'd5;
  localparam logic [DW-1:0] IDX_VW    = 16'd6;
  localparam logic [DW-1:0] IDX_VH    = 16'd7;
  localparam logic [DW-1:0] IDX_XOFF  = 16'd8;
  localparam logic [DW-1:0] IDX_YOFF  = 16'd9;
  localparam logic [DW-1:0] IDX_MEM   = 16'd10;

  localparam logic [DW-1:0] ID_LO     = 16'hB0C0;
  localparam logic [DW-1:0] ID_HI     = 16'hB0C5;

  localparam int EN_ON  = 0;
  localparam int EN_CAP = 1;
endpackage

// File: rtl/dispmode_fit.sv
`timescale 1ns/1ps
module dispmode_fit
  import dispmode_pkg::*;
#(
  parameter int unsigned FB_BYTES = 32'h0080_0000
) (
  input  logic [DW-1:0] xres_i,
  input  logic [DW-1:0] yres_i,
  output logic          fit_o
);
  localparam int PW = 2*DW + 2;

  logic [PW-1:0] bytes;
  logic          x_ok, y_ok, sz_ok;

  always_comb begin
    bytes = PW'(xres_i) * PW'(yres_i);
    bytes = bytes << 2;
    x_ok  = xres_i <= DW'(MAX_RES);
    y_ok  = yres_i <= DW'(MAX_RES);
    sz_ok = bytes <= PW'(FB_BYTES);
    fit_o = x_ok && y_ok && sz_ok;
  end
endmodule

// File: rtl/dispmode_geom.sv
`timescale 1ns/1ps
module dispmode_geom
  import dispmode_pkg::*;
#(
  parameter int unsigned FB_BYTES    = 32'h0080_0000,
  parameter int unsigned INIT_WIDTH  = 1920,
  parameter int unsigned INIT_HEIGHT = 1080
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] xres_i,
  input  logic [DW-1:0] yres_i,
  output logic [DW-1:0] width_o,
  output logic [DW-1:0] height_o,
  output logic [SW-1:0] stride_o
);
  localparam logic [DW-1:0] W0 = DW'(INIT_WIDTH);
  localparam logic [DW-1:0] H0 = DW'(INIT_HEIGHT);
  localparam logic [SW-1:0] S0 = SW'(INIT_WIDTH) << 2;

  logic fit;

  dispmode_fit #(.FB_BYTES(FB_BYTES)) u_fit (
    .xres_i (xres_i),
    .yres_i (yres_i),
    .fit_o  (fit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_o  <= W0;
      height_o <= H0;
      stride_o <= S0;
    end else if (load_i && fit) begin
      width_o  <= xres_i;
      height_o <= yres_i;
      stride_o <= SW'(xres_i) << 2;
    end
  end

  AST_GEOM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(width_o) && $stable(height_o) && $stable(stride_o)); // R4
  AST_GEOM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && xres_i <= DW'(MAX_RES) && yres_i <= DW'(MAX_RES) && xres_i == 16'd1 && yres_i == 16'd1)
    |=> width_o == 16'd1 && height_o == 16'd1); // R4
  AST_GEOM_BIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && xres_i > DW'(MAX_RES)) |=> $stable(width_o)); // R10
endmodule

// File: rtl/dispmode_regs.sv
`timescale 1ns/1ps
module dispmode_regs
  import dispmode_pkg::*;
#(
  parameter int unsigned FB_BYTES    = 32'h0080_0000,
  parameter int unsigned INIT_WIDTH  = 1920,
  parameter int unsigned INIT_HEIGHT = 1080
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic          off_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  output logic [15:0]   act_width_o,
  output logic [15:0]   act_height_o,
  output logic [17:0]   act_stride_o
);
  localparam logic [DW-1:0] MEM_UNITS = DW'(FB_BYTES >> 16);

  logic [DW-1:0] idx_q;
  logic [DW-1:0] regs_q [NUM_RW];
  logic          wr_ptr, wr_dat, mode_set, id_ok;
  logic [SW-1:0] stride;

  assign wr_ptr   = sel_i && we_i && !off_i;
  assign wr_dat   = sel_i && we_i && off_i;
  assign id_ok    = (wdata_i >= ID_LO) && (wdata_i <= ID_HI);
  assign mode_set = wr_dat && (idx_q == IDX_EN) && wdata_i[EN_ON] && !regs_q[4][EN_ON];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int i = 0; i < NUM_RW; i++) regs_q[i] <= (i == 0) ? ID_HI : '0;
    end else begin
      if (wr_ptr) idx_q <= wdata_i;
      if (wr_dat) begin
        case (idx_q)
          IDX_ID: if (id_ok) regs_q[0] <= wdata_i;
          IDX_EN: begin
            regs_q[4] <= wdata_i;
            if (mode_set) begin
              regs_q[6] <= regs_q[1];
              regs_q[7] <= regs_q[2];
              regs_q[8] <= '0;
              regs_q[9] <= '0;
            end
          end
          IDX_XRES, IDX_YRES, IDX_BPP, IDX_BANK,
          IDX_VW, IDX_VH, IDX_XOFF, IDX_YOFF: regs_q[idx_q[3:0]] <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  dispmode_geom #(
    .FB_BYTES    (FB_BYTES),
    .INIT_WIDTH  (INIT_WIDTH),
    .INIT_HEIGHT (INIT_HEIGHT)
  ) u_geom (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (mode_set),
    .xres_i   (regs_q[1]),
    .yres_i   (regs_q[2]),
    .width_o  (act_width_o),
    .height_o (act_height_o),
    .stride_o (stride)
  );
  assign act_stride_o = stride;

  // capability override takes priority over stored values for 1..3
  always_comb begin
    rdata_o = '0;
    if (!off_i) begin
      rdata_o = idx_q;
    end else if (regs_q[4][EN_CAP] && idx_q == IDX_XRES) begin
      rdata_o = act_width_o;
    end else if (regs_q[4][EN_CAP] && idx_q == IDX_YRES) begin
      rdata_o = act_height_o;
    end else if (regs_q[4][EN_CAP] && idx_q == IDX_BPP) begin
      rdata_o = DW'(CAP_BPP);
    end else if (idx_q == IDX_MEM) begin
      rdata_o = MEM_UNITS;
    end else if (idx_q < DW'(NUM_RW)) begin
      rdata_o = regs_q[idx_q[3:0]];
    end
  end

  AST_ID_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[0] >= ID_LO && regs_q[0] <= ID_HI); // R3
  AST_VIRT_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_set |=> regs_q[6] == $past(regs_q[1]) && regs_q[7] == $past(regs_q[2])); // R5
  AST_PAN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_set |=> regs_q[8] == '0 && regs_q[9] == '0); // R5
  AST_EN_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dat && idx_q == IDX_EN) |=> regs_q[4] == $past(wdata_i)); // R6
  AST_OOR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && off_i && idx_q >= DW'(NUM_REG)) |-> rdata_o == '0); // R8
endmodule

// File: tb/dispmode_regs_bench.sv
`timescale 1ns/1ps
module dispmode_regs_bench;
  localparam int unsigned FB  = 32'h0010_0000;
  localparam int unsigned IW  = 640;
  localparam int unsigned IH  = 400;

  logic        clk = 0, rst_n = 0;
  logic        sel = 0, we = 0, off = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata, aw, ah;
  logic [17:0] as;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dispmode_regs #(.FB_BYTES(FB), .INIT_WIDTH(IW), .INIT_HEIGHT(IH)) u_dispmode_regs (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .off_i(off),
    .wdata_i(wdata), .rdata_o(rdata), .act_width_o(aw), .act_height_o(ah),
    .act_stride_o(as)
  );

  typedef struct packed {
    logic        wr;
    logic        off;
    logic [15:0] data;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h0001, 16'h0000, 4'd1},  // R1 pointer
    '{1'b0, 1'b0, 16'h0000, 16'h0001, 4'd1},  // R1 readback
    '{1'b1, 1'b1, 16'd512,  16'h0000, 4'd9},
    '{1'b0, 1'b1, 16'h0000, 16'd512,  4'd9},  // R9 xres
    '{1'b1, 1'b0, 16'h0002, 16'h0000, 4'd9},
    '{1'b1, 1'b1, 16'd512,  16'h0000, 4'd9},
    '{1'b0, 1'b1, 16'h0000, 16'd512,  4'd9},  // R9 yres
    '{1'b1, 1'b0, 16'h0000, 16'h0000, 4'd3},
    '{1'b1, 1'b1, 16'h1234, 16'h0000, 4'd3},
    '{1'b0, 1'b1, 16'h0000, 16'hB0C5, 4'd3},  // R3 rejected
    '{1'b1, 1'b1, 16'hB0C0, 16'h0000, 4'd3},
    '{1'b0, 1'b1, 16'h0000, 16'hB0C0, 4'd3},  // R3 low end accepted
    '{1'b1, 1'b1, 16'hB0C6, 16'h0000, 4'd3},
    '{1'b0, 1'b1, 16'h0000, 16'hB0C0, 4'd3},  // R3 above range
    '{1'b1, 1'b1, 16'hB0BF, 16'h0000, 4'd3},
    '{1'b0, 1'b1, 16'h0000, 16'hB0C0, 4'd3},  // R3 below range
    '{1'b1, 1'b0, 16'h0003, 16'h0000, 4'd9},
    '{1'b1, 1'b1, 16'd8,    16'h0000, 4'd9},
    '{1'b0, 1'b1, 16'h0000, 16'd8,    4'd9},  // R9 bpp
    '{1'b1, 1'b0, 16'h0005, 16'h0000, 4'd9},
    '{1'b1, 1'b1, 16'hA5A5, 16'h0000, 4'd9},
    '{1'b0, 1'b1, 16'h0000, 16'hA5A5, 4'd9},  // R9 bank
    '{1'b1, 1'b0, 16'h0008, 16'h0000, 4'd9},
    '{1'b1, 1'b1, 16'd7,    16'h0000, 4'd9},
    '{1'b0, 1'b1, 16'h0000, 16'd7,    4'd9},  // R9 x offset
    '{1'b1, 1'b0, 16'h000A, 16'h0000, 4'd8},
    '{1'b1, 1'b1, 16'hFFFF, 16'h0000, 4'd8},
    '{1'b0, 1'b1, 16'h0000, 16'd16,   4'd8},  // R8 mem size read-only
    '{1'b1, 1'b0, 16'h000B, 16'h0000, 4'd8},
    '{1'b1, 1'b1, 16'h0005, 16'h0000, 4'd8},
    '{1'b0, 1'b1, 16'h0000, 16'h0000, 4'd8},  // R8 index 11
    '{1'b1, 1'b0, 16'hFFFF, 16'h0000, 4'd8},
    '{1'b0, 1'b1, 16'h0000, 16'h0000, 4'd8}   // R8 index 0xFFFF
  };

  task automatic wr(input logic o, input logic [15:0] d);
    @(negedge clk); sel = 1; we = 1; off = o; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(input logic o, output logic [15:0] d);
    @(negedge clk); sel = 1; we = 0; off = o;
    #2; d = rdata; sel = 0;
  endtask

  task automatic setr(input logic [15:0] i, input logic [15:0] d);
    wr(1'b0, i); wr(1'b1, d);
  endtask

  task automatic getr(input logic [15:0] i, output logic [15:0] d);
    wr(1'b0, i); rd(1'b1, d);
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic geom(input string r, input int w, input int h);
    chk(r, 32'(aw), 32'(w));
    chk(r, 32'(ah), 32'(h));
    chk(r, 32'(as), 32'(w * 4));
  endtask

  initial begin
    #(20 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    geom("R2", IW, IH);
    rd(1'b0, v);      chk("R2", v, 16'h0);
    getr(16'd0, v);   chk("R2", v, 16'hB0C5);
    getr(16'd10, v);  chk("R2", v, 16'd16);
    getr(16'd4, v);   chk("R2", v, 16'h0);
    getr(16'd6, v);   chk("R2", v, 16'h0);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].wr) wr(VECS[k].off, VECS[k].data);
      else begin
        rd(VECS[k].off, v);
        chk($sformatf("R%0d", VECS[k].req), v, VECS[k].exp);
      end
    end

    // R4 exact-fit mode set: 512*4*512 == FB
    setr(16'd9, 16'd9);
    setr(16'd6, 16'd100);
    setr(16'd4, 16'h0041);
    geom("R4", 512, 512);
    getr(16'd6, v); chk("R5", v, 16'd512);
    getr(16'd7, v); chk("R5", v, 16'd512);
    getr(16'd8, v); chk("R5", v, 16'd0);
    getr(16'd9, v); chk("R5", v, 16'd0);
    getr(16'd4, v); chk("R6", v, 16'h0041);

    // R6 re-write with bit 0 already set: no side effects
    setr(16'd1, 16'd320);
    setr(16'd6, 16'd77);
    setr(16'd8, 16'd3);
    setr(16'd4, 16'h00E1);
    geom("R6", 512, 512);
    getr(16'd6, v); chk("R6", v, 16'd77);
    getr(16'd8, v); chk("R6", v, 16'd3);
    getr(16'd4, v); chk("R6", v, 16'h00E1);

    // R4 one column over capacity: outputs hold, R5 side effects still occur
    setr(16'd4, 16'h0000);
    setr(16'd1, 16'd513);
    setr(16'd9, 16'd5);
    setr(16'd4, 16'h0001);
    geom("R4", 512, 512);
    getr(16'd6, v); chk("R5", v, 16'd513);
    getr(16'd9, v); chk("R5", v, 16'd0);

    // R10 width past limit with tiny height
    setr(16'd4, 16'h0000);
    setr(16'd1, 16'd4097);
    setr(16'd2, 16'd1);
    setr(16'd4, 16'h0001);
    geom("R10", 512, 512);

    // R4 width at limit
    setr(16'd4, 16'h0000);
    setr(16'd1, 16'd4096);
    setr(16'd2, 16'd64);
    setr(16'd4, 16'h0001);
    geom("R4", 4096, 64);

    // R7 capability override
    setr(16'd4, 16'h0000);
    setr(16'd1, 16'd100);
    setr(16'd2, 16'd50);
    setr(16'd4, 16'h0002);
    geom("R7", 4096, 64);
    getr(16'd1, v); chk("R7", v, 16'd4096);
    getr(16'd2, v); chk("R7", v, 16'd64);
    getr(16'd3, v); chk("R7", v, 16'd32);
    getr(16'd5, v); chk("R7", v, 16'hA5A5);
    setr(16'd4, 16'h0000);
    getr(16'd1, v); chk("R7", v, 16'd100);
    getr(16'd3, v); chk("R7", v, 16'd8);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule